// File: doc/BRIEF.md
# Shadowed PWM Channel with Prescaler

This block generates one pulse-width-modulated output from a 1 MHz reference tick. The tick arrives as a one-cycle enable on the system clock. A two-bit prescaler code divides the tick by 1, 2, 4 or 8. A 16-bit counter then runs through the programmed period. The output sits at its active level while the counter is below the duty value, and a polarity bit picks whether the active level is high or low.

Software programs three registers through a simple write strobe: control, duty, and period. Writes land in staging registers and have no effect on the output until the period register is written. That write arms a pending commit. The staged control, duty and period values then move together into the active set, either at the end of the period currently running or, when the channel is idle, at the next prescaled tick. This makes every configuration change atomic. Clearing the run enable lets the running period finish and then holds the output low.

Top module: `pwm_shadow_channel`

## Requirements
- R1: The register address selects the target: 0 is control (bits [1:0] prescaler code, bit 2 polarity invert), 1 is duty, and 2 is period. Address 3 is ignored. Control and duty writes alone never change the output.
- R2: One counter step takes 2^code reference ticks for prescaler codes 0 to 3, so one full period lasts period × 2^code reference ticks.
- R3: Within a period the output is active while the counter is below duty and inactive for the rest of the period. A duty of 0 gives a constant inactive output, and a duty at or above the period gives a constant active output.
- R4: With the invert bit set, the active level is low and the inactive level is high.
- R5: A period write arms a pending commit. When the running period ends, the staged control, duty and period values all become active in the same cycle, and the pending flag clears.
- R6: If the period is written twice before a boundary, only the values staged last are used, and exactly one commit takes place.
- R7: While the channel is idle and enabled, a pending commit takes effect at the next prescaled tick, and counting restarts from zero.
- R8: Clearing the run enable lets the running period complete. After that the output is held low whatever the polarity.
- R9: An active period of 0 keeps the channel stopped. While the run enable is high, the output sits at its inactive level.
- R10: After reset the output is low, nothing is pending, and the active period is 0.
- R11: The prescaler restarts at each commit, so the first period after a change has exactly the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse at the 1 MHz reference rate |
| run_en | input | 1 | Channel run enable; clearing it stops the channel after the running period completes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 duty, 2 period, 3 unused |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Some properties are checked on every cycle by assertions. These are that the active settings stay frozen except in a commit cycle, that a commit copies all staged fields at once, that the counter stays below the active period, that the pending flag follows period writes and commits, and that a stopped and disabled channel drives low. The bench's scenarios are needed for the timing properties. These are that a change waits for the period boundary, that a double period write yields a single commit, that the graceful stop occurs on the exact cycle, and that the high and low lengths are correct for every prescaler code and polarity. The bench covers these with a cycle-accurate reference model, under both directed sequences and random programming.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  // Register select codes; the bench and software rely on these values.
  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_DUTY = 2'd1,
    REG_PER  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_INV_BIT = 2;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [PRE_W-1:0]  stg_pre,
  output logic              stg_inv,
  output logic [DATA_W-1:0] stg_duty,
  output logic [DATA_W-1:0] stg_per,
  output logic              pending
);
  reg_sel_e sel;
  logic     wr_per;
  logic     unused_hi;

  assign sel       = reg_sel_e'(wr_addr);
  assign wr_per    = wr_en && (sel == REG_PER);
  assign unused_hi = ^wr_data[DATA_W-1:CTL_INV_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_pre  <= '0;
      stg_inv  <= 1'b0;
      stg_duty <= '0;
      stg_per  <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_CTL: begin
          stg_pre <= wr_data[PRE_W-1:0];
          stg_inv <= wr_data[CTL_INV_BIT];
        end
        REG_DUTY: stg_duty <= wr_data;
        REG_PER:  stg_per  <= wr_data;
        default: ;
      endcase
    end
  end

  // A write in the commit cycle re-arms, so the newer values commit later.
  always_ff @(posedge clk) begin
    if (rst)         pending <= 1'b0;
    else if (wr_per) pending <= 1'b1;
    else if (commit) pending <= 1'b0;
  end

  p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
    wr_per |=> pending);
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (commit && !wr_per) |=> !pending);
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PRE_W-1:0] act_pre,
  input  logic             commit,
  output logic             ptick
);
  localparam int unsigned PCNT_W = (1 << PRE_W) - 1;

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] lim;

  // Limit is 2^code - 1.
  assign lim   = ~({PCNT_W{1'b1}} << act_pre);
  assign ptick = tick && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (rst)        pcnt <= '0;
    else if (commit) pcnt <= '0;
    else if (tick)  pcnt <= ptick ? '0 : pcnt + 1'b1;
  end

  p_pcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    pcnt <= lim);
  p_pcnt_restart_r11: assert property (@(posedge clk) disable iff (rst)
    commit |=> (pcnt == '0));
endmodule

// File: rtl/pwm_counter_core.sv
module pwm_counter_core #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptick,
  input  logic              run_en,
  input  logic              pending,
  input  logic [PRE_W-1:0]  stg_pre,
  input  logic              stg_inv,
  input  logic [DATA_W-1:0] stg_duty,
  input  logic [DATA_W-1:0] stg_per,
  output logic              commit,
  output logic              running,
  output logic [DATA_W-1:0] cnt,
  output logic [PRE_W-1:0]  act_pre,
  output logic              act_inv,
  output logic [DATA_W-1:0] act_duty,
  output logic [DATA_W-1:0] act_per
);
  logic              at_end;
  logic              nxt_run;
  logic [DATA_W-1:0] nxt_cnt;
  logic [DATA_W-1:0] eff_per;

  assign at_end  = (cnt == act_per - DATA_W'(1));
  assign eff_per = commit ? stg_per : act_per;

  always_comb begin
    commit  = 1'b0;
    nxt_run = running;
    nxt_cnt = cnt;
    if (ptick) begin
      if (running) begin
        if (at_end) begin
          commit  = pending;
          nxt_cnt = '0;
          nxt_run = run_en && (eff_per != '0);
        end else begin
          nxt_cnt = cnt + DATA_W'(1);
        end
      end else if (run_en) begin
        commit  = pending;
        nxt_cnt = '0;
        nxt_run = (eff_per != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      cnt      <= '0;
      act_pre  <= '0;
      act_inv  <= 1'b0;
      act_duty <= '0;
      act_per  <= '0;
    end else begin
      running <= nxt_run;
      cnt     <= nxt_cnt;
      if (commit) begin
        act_pre  <= stg_pre;
        act_inv  <= stg_inv;
        act_duty <= stg_duty;
        act_per  <= stg_per;
      end
    end
  end

  p_atomic_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_pre) && $stable(act_inv) &&
                 $stable(act_duty) && $stable(act_per)));
  p_atomic_load_r5: assert property (@(posedge clk) disable iff (rst)
    commit |=> (act_per == $past(stg_per) && act_duty == $past(stg_duty) &&
                act_pre == $past(stg_pre) && act_inv == $past(stg_inv)));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < act_per));
  p_commit_armed_r7: assert property (@(posedge clk) disable iff (rst)
    commit |-> pending);
endmodule

// File: rtl/pwm_shadow_channel.sv
module pwm_shadow_channel #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);
  logic              commit, pending, ptick, running;
  logic [PRE_W-1:0]  stg_pre, act_pre;
  logic              stg_inv, act_inv;
  logic [DATA_W-1:0] stg_duty, stg_per, act_duty, act_per, cnt;
  logic              out_nxt;

  pwm_stage_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .stg_pre(stg_pre),
    .stg_inv(stg_inv), .stg_duty(stg_duty), .stg_per(stg_per),
    .pending(pending)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst(rst), .tick(ref_tick), .act_pre(act_pre),
    .commit(commit), .ptick(ptick)
  );

  pwm_counter_core #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst(rst), .ptick(ptick), .run_en(run_en),
    .pending(pending), .stg_pre(stg_pre), .stg_inv(stg_inv),
    .stg_duty(stg_duty), .stg_per(stg_per), .commit(commit),
    .running(running), .cnt(cnt), .act_pre(act_pre), .act_inv(act_inv),
    .act_duty(act_duty), .act_per(act_per)
  );

  // Stopped: inactive level when enabled with period 0, otherwise forced low.
  always_comb begin
    if (running)                         out_nxt = (cnt < act_duty) ^ act_inv;
    else if (run_en && act_per == '0)    out_nxt = act_inv;
    else                                 out_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= out_nxt;
  end

  p_stop_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!running && !run_en) |=> !pwm_out);
  p_zero_period_r9: assert property (@(posedge clk) disable iff (rst)
    (run_en && act_per == '0) |=> (pwm_out == $past(act_inv)));
  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> (!pwm_out && !pending && act_per == '0));
endmodule

// File: tb/tb_pwm_shadow_channel.sv
module tb_pwm_shadow_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        run_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;

  pwm_shadow_channel dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .run_en(run_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  string tag      = "R10";
  bit    done     = 0;

  // Reference model state
  int m_pcnt, m_cnt, a_pre, a_inv, a_duty, a_per, s_pre, s_inv, s_duty, s_per;
  bit m_run, m_pend;
  int exp_out;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_pcnt = 0; m_cnt = 0; m_run = 0; m_pend = 0;
    a_pre = 0; a_inv = 0; a_duty = 0; a_per = 0;
    s_pre = 0; s_inv = 0; s_duty = 0; s_per = 0;
  endtask

  // Expected behaviour, derived from R1..R11, one clock at a time.
  task automatic model_clock();
    int  lim;
    bit  pt, cm;
    if (m_run)                  exp_out = ((m_cnt < a_duty) ? 1 : 0) ^ a_inv;
    else if (run_en && a_per == 0) exp_out = a_inv;
    else                        exp_out = 0;
    lim = (1 << a_pre) - 1;
    pt  = ref_tick && (m_pcnt == lim);
    cm  = 0;
    if (pt && (!m_run || m_cnt == a_per - 1) && (m_run || run_en)) begin
      bit was_run = m_run;
      cm = m_pend;
      if (cm) begin
        a_pre = s_pre; a_inv = s_inv; a_duty = s_duty; a_per = s_per;
      end
      m_cnt = 0;
      m_run = (was_run ? run_en : 1'b1) && (a_per != 0);
    end else if (pt && m_run) begin
      m_cnt++;
    end
    if (cm)            m_pcnt = 0;
    else if (ref_tick) m_pcnt = pt ? 0 : m_pcnt + 1;
    if (cm) m_pend = 0;
    if (wr_en) begin
      if (wr_addr == 2'd0) begin s_pre = wr_data[1:0]; s_inv = wr_data[2]; end
      if (wr_addr == 2'd1) s_duty = wr_data;
      if (wr_addr == 2'd2) begin s_per = wr_data; m_pend = 1; end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_clock();
    #1;
    cyc++;
    check(tag, pwm_out, exp_out);
    wr_en    = 1'b0;
    ref_tick = (cyc % 4 == 3);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    step();
  endtask

  task automatic program_all(int ctl, int duty, int per);
    wr(0, ctl); wr(1, duty); wr(2, per);
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9157));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tag = "R10"; check("R10", pwm_out, 0);
    run(8);

    // R1: staged writes alone, not enabled, no effect
    tag = "R1";
    wr(0, 3'b100); wr(1, 5); wr(3, 9);
    run(40);
    check("R1", pwm_out, 0);

    // R7: idle commit at next prescaled tick
    tag = "R7";
    wr(2, 8);
    run_en = 1'b1;
    run(80);

    // R3: duty 0 and duty above period
    tag = "R3"; program_all(0, 0, 6); run(120);
    check("R3", pwm_out, 0);
    tag = "R3"; program_all(0, 20, 6); run(120);
    check("R3", pwm_out, 1);

    // R4: inverted polarity
    tag = "R4"; program_all(3'b100, 3, 7); run(150);

    // R2 / R11: each prescaler code
    for (int c = 0; c < 4; c++) begin
      tag = (c == 3) ? "R11" : "R2";
      program_all(c, 2, 5);
      run(5 * 4 * (1 << c) * 2 + 40);
    end

    // R1: control and duty writes without a period write stay staged
    tag = "R1"; wr(0, 0); wr(1, 1); run(200);

    // R5 / R6: double period write before a boundary
    tag = "R5"; program_all(0, 2, 9); run(20);
    tag = "R6"; wr(1, 4); wr(2, 6); wr(1, 1); wr(2, 3); run(150);

    // R8: graceful stop with invert set
    tag = "R8"; program_all(3'b100, 2, 6); run(60);
    run_en = 1'b0; run(120);
    check("R8", pwm_out, 0);

    // R9: zero period, enabled
    tag = "R9"; run_en = 1'b1; program_all(3'b100, 2, 0); run(60);
    check("R9", pwm_out, 1);
    tag = "R9"; program_all(0, 2, 0); run(60);
    check("R9", pwm_out, 0);

    // Random programming and enable toggles
    for (int it = 0; it < 40; it++) begin
      tag = "R5";
      if ($urandom % 4 == 0) wr($urandom % 4, $urandom % 16);
      if ($urandom % 3 != 0)
        program_all($urandom % 8, $urandom % 14, $urandom % 12);
      if ($urandom % 5 == 0) run_en = ~run_en;
      run(40 + ($urandom % 300));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule